// File: doc/BRIEF.md
# Truncated-Output Radix-4 Signed Multiplier with Adaptive Error Correction

This block multiplies two N-bit two's-complement operands and returns only the upper half of the 2N-bit product, which is what most fixed-point datapaths keep. Full partial-product rows are produced by radix-4 recoding of the multiplier operand. Every row bit that falls below the bit just under the output LSB is never built, which roughly halves the reduction array. The remaining bits are reduced by a chain of 3:2 carry-save stages and one carry-propagate adder.

The discarded low part is not replaced by a fixed bias. A correction is estimated from how many recoded digits are nonzero: each nonzero digit brings a row whose dropped bits average about a quarter of an output LSB. That estimate, together with half an LSB for rounding, enters the array as a small count at the column just under the output LSB. The result may be registered (default) or left combinational.

Top module: `fwm_booth_mult`

## Requirements
- R1: Digit j (j = 0 .. N/2-1) of operand b is d_j = -2*b[2j+1] + b[2j] + b[2j-1], with b[-1] = 0. A triple of three ones yields d_j = 0 and an all-zero row, not an inverted one.
- R2: Row j holds the N+1-bit two's-complement value of |d_j|*a, bit-inverted when d_j < 0, placed at column 2j. The +1 that completes the negation sits at column 2j and is discarded with the other low bits.
- R3: Sign extension is replaced by inverting the top bit of each row and adding the constant -sum_j 2^(N+2j). A row with d_j = 0 therefore contributes only a single one at column N+2j.
- R4: Only row bits at columns N-1 and above are summed. Every bit below column N-1 is dropped.
- R5: With z the number of nonzero digits, the correction floor((z+3)/2) is added at column N-1. It is at least 1 and at most floor((N/2+3)/2).
- R6: The output is the N-bit two's-complement value floor(S / 2^N) mod 2^N, where S is the sum of the kept bits, the constant and the correction. For a = b = 127 (N = 8) the output is 64.
- R7: The output differs from the exact product rounded to nearest (half up, floor((a*b + 2^(N-1)) / 2^N)) by -2 to +1 output LSB.
- R8: Over all operand pairs for N = 8, the mean absolute error against the rounded exact product is smaller than that of plain truncation, floor(a*b / 2^N).
- R9: With REG_OUT = 1, p_o shows the result for the operands present at the previous rising clock edge. An active-low asynchronous reset forces p_o to 0 at once.
- R10: When b is zero, the output is 0 for every a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | N | Multiplicand, two's complement |
| b_i | input | N | Multiplier, two's complement, radix-4 recoded |
| p_o | output | N | Upper N bits of the approximate product |

## Verification
Every one of the 65,536 operand pairs for N = 8 is applied. Each result is compared with an arithmetic model built from the digit, row, constant and correction rules, and with the rounded exact product. Together these separate a fault in the recoding, in the windowing or in the correction from a fault in the adder. A hand-computed pair (127 x 127), the extreme pairs around -128, zero multipliers, and multipliers made of all-ones triples test the -0 digit, sign-constant and overflow edges. A change in the input within a cycle and a reset in mid-stream show the register timing.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

  typedef struct packed {
    logic neg;
    logic two;
    logic one;
  } booth_dig_t;

  // sign-extension constant, aligned so bit 0 is product column N-1
  function automatic longint sign_const_win(int unsigned rows);
    longint acc;
    acc = 0;
    for (int unsigned j = 0; j < rows; j++) begin
      acc = acc - (longint'(1) << (2 * j + 1));
    end
    return acc;
  endfunction

endpackage

// File: rtl/fwm_booth_row.sv
module fwm_booth_row
  import fwm_pkg::*;
#(
  parameter int unsigned N = 8,
  parameter int unsigned J = 0
) (
  input  logic [N-1:0] a_i,
  input  logic [2:0]   trip_i,
  output logic [N:0]   row_o,
  output logic         nz_o
);

  localparam int unsigned LO = N - 1 - 2 * J;

  booth_dig_t dig;
  logic [N:0] sel;
  logic [N:0] inv;
  logic [N:0] ext;
  logic       low_unused;

  always_comb begin
    dig.one = trip_i[1] ^ trip_i[0];
    dig.two = (trip_i[2] & ~trip_i[1] & ~trip_i[0]) |
              (~trip_i[2] & trip_i[1] & trip_i[0]);
    // all-ones triple is zero, not negative zero
    dig.neg = trip_i[2] & ~(trip_i[1] & trip_i[0]);
  end

  always_comb begin
    if (dig.one)      sel = {a_i[N-1], a_i};
    else if (dig.two) sel = {a_i, 1'b0};
    else              sel = '0;
  end

  assign inv  = sel ^ {(N+1){dig.neg}};
  assign ext  = {~inv[N], inv[N-1:0]};
  assign nz_o = dig.one | dig.two;

  // keep columns N-1 and up; bit t of the window is column N-1+t
  for (genvar t = 0; t <= N; t++) begin : g_win
    if (t + LO <= N) begin : g_keep
      assign row_o[t] = ext[t+LO];
    end else begin : g_zero
      assign row_o[t] = 1'b0;
    end
  end

  assign low_unused = ^ext[LO-1:0];

endmodule

// File: rtl/fwm_comp.sv
module fwm_comp #(
  parameter int unsigned ROWS = 4,
  parameter int unsigned W    = 9
) (
  input  logic [ROWS-1:0] nz_i,
  output logic [W-1:0]    comp_o
);

  localparam int unsigned CW = $clog2(ROWS + 4);

  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int unsigned i = 0; i < ROWS; i++) begin
      cnt = cnt + CW'(nz_i[i]);
    end
  end

  // quarter LSB per nonzero digit plus half LSB rounding, in column N-1 units
  assign comp_o = W'((cnt + CW'(3)) >> 1);

endmodule

// File: rtl/fwm_csa_tree.sv
module fwm_csa_tree #(
  parameter int unsigned W = 9,
  parameter int unsigned M = 6
) (
  input  logic [M-1:0][W-1:0] ops_i,
  output logic [W-1:0]        sum_o
);

  logic [M-2:0][W-1:0] s_q;
  logic [M-2:0][W-1:0] c_q;

  assign s_q[0] = ops_i[0];
  assign c_q[0] = ops_i[1];

  for (genvar i = 0; i < M - 2; i++) begin : g_csa
    logic [W-2:0] maj;
    assign s_q[i+1] = s_q[i] ^ c_q[i] ^ ops_i[i+2];
    assign maj = (s_q[i][W-2:0] & c_q[i][W-2:0]) |
                 (s_q[i][W-2:0] & ops_i[i+2][W-2:0]) |
                 (c_q[i][W-2:0] & ops_i[i+2][W-2:0]);
    assign c_q[i+1] = {maj, 1'b0};
  end

  assign sum_o = s_q[M-2] + c_q[M-2];

endmodule

// File: rtl/fwm_booth_mult.sv
module fwm_booth_mult
  import fwm_pkg::*;
#(
  parameter int unsigned N       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] p_o
);

  localparam int unsigned ROWS = N / 2;
  localparam int unsigned W    = N + 1;
  localparam int unsigned OPS  = ROWS + 2;
  localparam int unsigned CMAX = (ROWS + 3) / 2;
  localparam logic [W-1:0] K_WIN = W'(sign_const_win(ROWS));

  logic [N:0]                b_ext;
  logic [ROWS-1:0][W-1:0]    rows;
  logic [ROWS-1:0]           nz;
  logic [W-1:0]              comp_op;
  logic [OPS-1:0][W-1:0]     ops;
  logic [W-1:0]              win_sum;
  logic [N-1:0]              p_d;
  logic                      lsb_unused;

  assign b_ext = {b_i, 1'b0};

  for (genvar j = 0; j < ROWS; j++) begin : g_row
    fwm_booth_row #(.N(N), .J(j)) u_row (
      .a_i   (a_i),
      .trip_i(b_ext[2*j+2 -: 3]),
      .row_o (rows[j]),
      .nz_o  (nz[j])
    );
    assign ops[j] = rows[j];
  end

  fwm_comp #(.ROWS(ROWS), .W(W)) u_comp (
    .nz_i  (nz),
    .comp_o(comp_op)
  );

  assign ops[ROWS]   = K_WIN;
  assign ops[ROWS+1] = comp_op;

  fwm_csa_tree #(.W(W), .M(OPS)) u_tree (
    .ops_i(ops),
    .sum_o(win_sum)
  );

  assign p_d        = win_sum[W-1:1];
  assign lsb_unused = win_sum[0];

  if (REG_OUT) begin : g_reg
    logic [N-1:0] p_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) p_q <= '0;
      else         p_q <= p_d;
    end
    assign p_o = p_q;
  end else begin : g_comb
    assign p_o = p_d;
  end

  // error window against the rounded exact product
  logic signed [2*N-1:0] exact_p;
  logic signed [2*N-1:0] rnd_p;
  logic signed [N+1:0]   err_d;

  assign exact_p = $signed(a_i) * $signed(b_i);
  assign rnd_p   = (exact_p + $signed((2*N)'(1) << (N - 1))) >>> N;
  assign err_d   = $signed({{2{p_d[N-1]}}, p_d}) - $signed(rnd_p[N+1:0]);

  p_err_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_d >= -2) && (err_d <= 1));

  p_zero_mult_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_i == '0) |-> (p_d == '0));

  p_comp_bounds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comp_op >= W'(1)) && (comp_op <= W'(CMAX)) &&
    (($countones(nz) == 0) == (comp_op == W'(1))));

  for (genvar j = 0; j < ROWS; j++) begin : g_row_chk
    p_zero_row_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !nz[j] |-> (rows[j] == (W'(1) << (2 * j + 1))));
  end

endmodule

// File: tb/tb_fwm_booth_mult.sv
module tb_fwm_booth_mult;

  localparam int N = 8;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] a;
  logic [N-1:0] b;
  logic [N-1:0] p;

  int checks = 0;
  int errors = 0;
  longint sum_abs_fw = 0;
  longint sum_abs_tr = 0;
  bit done = 0;

  fwm_booth_mult #(.N(N), .REG_OUT(1'b1)) dut (
    .clk_i (clk),
    .rst_ni(rst_n),
    .a_i   (a),
    .b_i   (b),
    .p_o   (p)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // arithmetic model of R1-R6
  function automatic int fw_model(input int av, input int bv);
    longint s;
    int nz;
    logic [8:0] bb;
    s  = 0;
    nz = 0;
    bb = {bv[7:0], 1'b0};
    for (int j = 0; j < N / 2; j++) begin
      int d;
      int mag;
      int lo;
      longint sel;
      d   = -2 * int'(bb[2*j+2]) + int'(bb[2*j+1]) + int'(bb[2*j]);
      mag = (d < 0) ? -d : d;
      sel = longint'(mag * av) & 64'h1FF;
      if (d < 0) sel = (~sel) & 64'h1FF;
      sel = sel ^ 64'h100;
      lo  = N - 1 - 2 * j;
      sel = sel & ~((longint'(1) << lo) - 1);
      s   = s + (sel << (2 * j));
      s   = s - (longint'(1) << (N + 2 * j));
      if (d != 0) nz++;
    end
    s = s + (longint'((nz + 3) / 2) << (N - 1));
    return ((int'(s >>> N) + 128) & 255) - 128;
  endfunction

  function automatic int rnd_exact(input int av, input int bv);
    return (av * bv + 128) >>> 8;
  endfunction

  function automatic int trunc_exact(input int av, input int bv);
    return (av * bv) >>> 8;
  endfunction

  function automatic int sgn8(input logic [7:0] v);
    return int'($signed(v));
  endfunction

  task automatic check_result(input int av, input int bv, input int act);
    int e_fw;
    int e_tr;
    chk(act == fw_model(av, bv), "R6 model match", act, fw_model(av, bv));
    e_fw = act - rnd_exact(av, bv);
    chk((e_fw >= -2) && (e_fw <= 1), "R7 error window", e_fw, 0);
    e_tr = trunc_exact(av, bv) - rnd_exact(av, bv);
    sum_abs_fw += (e_fw < 0) ? -e_fw : e_fw;
    sum_abs_tr += (e_tr < 0) ? -e_tr : e_tr;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    a = 8'd5;
    b = 8'd7;
    repeat (3) @(negedge clk);
    chk(p == '0, "R9 output zero in reset", sgn8(p), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_hand_value();
    @(negedge clk);
    a = 8'd3;
    b = 8'd0;
    @(negedge clk);
    chk(p == '0, "R10 zero multiplier", sgn8(p), 0);
    a = 8'd127;
    b = 8'd127;
    #1;
    chk(p == '0, "R9 no change before edge", sgn8(p), 0);
    @(negedge clk);
    chk(sgn8(p) == 64, "R6 127x127 hand value", sgn8(p), 64);
    chk(fw_model(127, 127) == 64, "R5 model hand value", fw_model(127, 127), 64);
  endtask

  task automatic t_zero_mult();
    for (int av = -128; av < 128; av += 37) begin
      @(negedge clk);
      a = av[7:0];
      b = 8'd0;
      @(negedge clk);
      chk(p == '0, "R10 zero multiplier sweep", sgn8(p), 0);
    end
  endtask

  task automatic t_neg_zero_digits();
    // b = -1: upper triples all ones, digit 0 is -1 (R1, R2)
    int bl[3] = '{-1, -64, 127};
    foreach (bl[i]) begin
      for (int av = -128; av < 128; av += 51) begin
        @(negedge clk);
        a = av[7:0];
        b = bl[i][7:0];
        @(negedge clk);
        chk(sgn8(p) == fw_model(av, bl[i]), "R1 all-ones triples", sgn8(p), fw_model(av, bl[i]));
      end
    end
  endtask

  task automatic t_extremes();
    int ea[6] = '{-128, -128, 127, 0, -1, 1};
    int eb[6] = '{-128, 127, -128, -1, -1, 1};
    foreach (ea[i]) begin
      @(negedge clk);
      a = ea[i][7:0];
      b = eb[i][7:0];
      @(negedge clk);
      chk(sgn8(p) == fw_model(ea[i], eb[i]), "R3 sign constant extremes", sgn8(p), fw_model(ea[i], eb[i]));
      chk(sgn8(p) - rnd_exact(ea[i], eb[i]) <= 1, "R4 extremes within window",
          sgn8(p) - rnd_exact(ea[i], eb[i]), 0);
    end
  endtask

  task automatic t_exhaustive();
    int pa;
    int pb;
    bit have;
    have = 1'b0;
    pa = 0;
    pb = 0;
    sum_abs_fw = 0;
    sum_abs_tr = 0;
    for (int av = -128; av < 128; av++) begin
      for (int bv = -128; bv < 128; bv++) begin
        @(negedge clk);
        if (have) check_result(pa, pb, sgn8(p));
        a = av[7:0];
        b = bv[7:0];
        pa = av;
        pb = bv;
        have = 1'b1;
      end
    end
    @(negedge clk);
    check_result(pa, pb, sgn8(p));
    chk(sum_abs_fw < sum_abs_tr, "R8 mean error below truncation",
        int'(sum_abs_fw), int'(sum_abs_tr));
  endtask

  task automatic t_async_reset();
    @(negedge clk);
    a = 8'd127;
    b = 8'd127;
    @(negedge clk);
    chk(sgn8(p) == 64, "R9 value before reset", sgn8(p), 64);
    #2;
    rst_n = 1'b0;
    #1;
    chk(p == '0, "R9 asynchronous clear", sgn8(p), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sgn8(p) == 64, "R9 resumes after reset", sgn8(p), 64);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_hand_value();
    t_zero_mult();
    t_neg_zero_digits();
    t_extremes();
    t_exhaustive();
    t_async_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule